// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block searches for the reference divider M, the feedback multiplier N and the power-of-two post-divider P of a PLL. These three values bring the PLL output as close as possible to a requested frequency. Every frequency on its pins is unsigned fixed point in MHz, with `FW` fractional bits (16 by default). A request beat carries five values: the target frequency, the reference frequency, the VCO lower and upper limits, and a ceiling for the output clock. It also carries a profile bit that chooses a pixel-clock rule set or a system-clock rule set. The engine captures all of these on acceptance. It limits the target to the range the PLL can reach. It then tries each candidate in turn, one N division and one output-frequency division per candidate, and keeps the candidate with the smallest error.

Both edges are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle, so a source holds its beat until then. The result is presented with `res_valid` and stays unchanged until `res_ready` is seen high on a clock edge. No new request is taken before that. The result consumer can stall without limit, and the engine simply waits.

Top module: `pll_coef_search`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle. `busy` rises in the cycle after a request is accepted and stays high until `res_valid` rises. `busy`, `res_valid` and `req_ready` are never high in pairs. While `res_valid` is high and `res_ready` is low, every result field holds its value.
- R2: The target is first raised to floor(vco_min/16) if it is below that value. It is then lowered to the upper limit if it is above it. The upper limit is `cfg_max_clk` in pixel profile and `cfg_vco_max` in system profile. All later steps use this limited target.
- R3: Post-divider values are tried in the order P = 1, 2, 4, 8, 16. A P value is used only if target×P lies in [vco_min, vco_max], bounds included.
- R4: In pixel profile (`req_sys_mode`=0), M is tried from 7 to 14 in ascending order. A value of M is used only if ref/M lies in [1.0, 2.0] MHz, bounds included.
- R5: In system profile (`req_sys_mode`=1), M is tried from 1 up to a limit, in ascending order. The limit is taken from the target before limiting: 2 if the target is above 340.0 MHz, 6 if it is above 250.0 MHz, and 14 otherwise. A value of M is used only if ref/M lies in [1.0, 14.0] MHz.
- R6: N = floor((2×target×P×M + ref)/(2×ref)), which is target×P×M/ref rounded half up. A candidate whose N is outside 1..255 is dropped.
- R7: For each candidate, the achieved frequency is floor(ref×N/(M×P)) in the fixed-point format. The error is |target − achieved|. A candidate replaces the kept one only if its error is strictly smaller, so among equal errors the earliest candidate wins. The search order is P in the outer loop and M in the inner loop.
- R8: The result gives `res_m` = M and `res_n` = N. `res_p_code` is log2(P), so P values 1, 2, 4, 8, 16 give codes 0 to 4. `res_freq` is the low `W` bits of the achieved frequency of the kept candidate.
- R9: When no candidate passes, `res_none` is 1 and `res_m`, `res_n`, `res_p_code` and `res_freq` are all 0. When a candidate passes, `res_none` is 0.
- R10: After reset, `req_ready` is 1, `busy` and `res_valid` are 0, and all result fields are 0.
- R11: Changes on `req_freq`, `req_sys_mode` or any `cfg_*` input after acceptance have no effect on the result of the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Engine idle, will take a request |
| req_freq | input | W | Requested output frequency, fixed point MHz |
| req_sys_mode | input | 1 | 0 = pixel profile, 1 = system profile |
| cfg_ref | input | W | Reference frequency |
| cfg_vco_min | input | W | VCO lower limit |
| cfg_vco_max | input | W | VCO upper limit |
| cfg_max_clk | input | W | Output ceiling used in pixel profile |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_m | output | 4 | Chosen reference divider |
| res_n | output | 8 | Chosen feedback multiplier |
| res_p_code | output | 3 | log2 of chosen post-divider |
| res_freq | output | W | Achieved output frequency, fixed point MHz |
| res_none | output | 1 | No valid candidate was found |
| busy | output | 1 | Search in progress |

## Verification
An error in the loop counters or in the constraint checks shows up only once the search ends. The earliest sign is the result beat, several thousand cycles after acceptance: a wrong M, N or code, or an achieved frequency that differs from the one recomputed from the port values. A fault in the strict-compare rule shows only where two candidates have the same error, so the stimulus mixes references that give ties with ones that do not. A fault in the handshake shows within one cycle: `req_ready`, `busy` or a stalled result changes on a clock edge where it must not.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;
  localparam int MW      = 4;   // width of M
  localparam int NBITS   = 8;   // width of N
  localparam int PCW     = 3;   // width of P code and P loop index
  localparam int DHW     = 8;   // width of discriminator bound in whole MHz
  localparam int N_MAX   = 255;
  localparam int P_STEPS = 5;   // P = 1,2,4,8,16

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PCHK,
    ST_MCHK,
    ST_NWAIT,
    ST_ASTART,
    ST_AWAIT,
    ST_DONE
  } srch_state_t;
endpackage

// File: rtl/pll_clamp.sv
module pll_clamp
  import pllsrch_pkg::*;
#(
  parameter int W            = 32,
  parameter int FW           = 16,
  parameter int VCO_SHIFT    = 4,
  parameter int M_PIX_LO     = 7,
  parameter int M_PIX_HI     = 14,
  parameter int M_SYS_LO     = 1,
  parameter int M_SYS_WIDE   = 14,
  parameter int M_SYS_MID    = 6,
  parameter int M_SYS_NARROW = 2,
  parameter int THR_HI_MHZ   = 340,
  parameter int THR_MID_MHZ  = 250,
  parameter int DISC_PIX_MHZ = 2,
  parameter int DISC_SYS_MHZ = 14
) (
  input  logic           sys_mode,
  input  logic [W-1:0]   target,
  input  logic [W-1:0]   vco_min,
  input  logic [W-1:0]   vco_max,
  input  logic [W-1:0]   max_clk,
  output logic [W-1:0]   limited,
  output logic [MW-1:0]  m_first,
  output logic [MW-1:0]  m_last,
  output logic [DHW-1:0] disc_hi
);
  localparam logic [W-1:0] THR_HI_FX  = W'(THR_HI_MHZ)  << FW;
  localparam logic [W-1:0] THR_MID_FX = W'(THR_MID_MHZ) << FW;

  logic [W-1:0] floor_v;
  logic [W-1:0] ceil_v;
  logic [W-1:0] raised;

  always_comb begin
    floor_v = vco_min >> VCO_SHIFT;
    ceil_v  = sys_mode ? vco_max : max_clk;
    raised  = (target < floor_v) ? floor_v : target;
    limited = (raised > ceil_v) ? ceil_v : raised;
  end

  always_comb begin
    if (!sys_mode) begin
      m_first = MW'(M_PIX_LO);
      m_last  = MW'(M_PIX_HI);
      disc_hi = DHW'(DISC_PIX_MHZ);
    end else begin
      m_first = MW'(M_SYS_LO);
      disc_hi = DHW'(DISC_SYS_MHZ);
      if (target > THR_HI_FX)       m_last = MW'(M_SYS_NARROW);
      else if (target > THR_MID_FX) m_last = MW'(M_SYS_MID);
      else                          m_last = MW'(M_SYS_WIDE);
    end
  end
endmodule

// File: rtl/pll_cand.sv
module pll_cand
  import pllsrch_pkg::*;
#(
  parameter int W  = 32,
  parameter int FW = 16,
  parameter int NW = W + 8,
  parameter int DW = W + 1
) (
  input  logic [W-1:0]   limited,
  input  logic [PCW-1:0] pidx,
  input  logic [MW-1:0]  m,
  input  logic [W-1:0]   ref_clk,
  input  logic [W-1:0]   vco_min,
  input  logic [W-1:0]   vco_max,
  input  logic [DHW-1:0] disc_hi,
  output logic           vco_ok,
  output logic           disc_ok,
  output logic [NW-1:0]  n_num,
  output logic [DW-1:0]  n_den
);
  localparam int VW = W + 4;

  logic [VW-1:0] vco;
  logic [NW-1:0] lo_lim;
  logic [NW-1:0] hi_lim;

  always_comb begin
    vco     = VW'(limited) << pidx;
    vco_ok  = (vco >= VW'(vco_min)) && (vco <= VW'(vco_max));
    lo_lim  = NW'(m) << FW;
    hi_lim  = (NW'(m) * NW'(disc_hi)) << FW;
    disc_ok = (NW'(ref_clk) >= lo_lim) && (NW'(ref_clk) <= hi_lim);
    n_num   = ((NW'(vco) * NW'(m)) << 1) + NW'(ref_clk);
    n_den   = {ref_clk, 1'b0};
  end
endmodule

// File: rtl/pll_div.sv
module pll_div #(
  parameter int NW = 40,
  parameter int DW = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW);

  logic [NW-1:0] dvd_q;
  logic [NW-1:0] num_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;
  logic [DW-1:0] rem_nx;
  logic [NW-1:0] dvd_nx;

  always_comb begin
    trial  = {rem_q, dvd_q[NW-1]};
    diff   = trial - {1'b0, den_q};
    ge     = trial >= {1'b0, den_q};
    rem_nx = ge ? DW'(diff) : DW'(trial);
    dvd_nx = {dvd_q[NW-2:0], ge};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        dvd_q  <= num;
        num_q  <= num;
        den_q  <= den;
        rem_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nx;
        dvd_q <= dvd_nx;
        if (cnt_q == CW'(NW - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = dvd_q;

  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> (({{DW{1'b0}}, dvd_q} * {{NW{1'b0}}, den_q}) + {{NW{1'b0}}, rem_q}) == {{DW{1'b0}}, num_q}); // R6
  AST_DIV_REM_LT: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> rem_q < den_q); // R6
  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> !start); // R7
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pllsrch_pkg::*;
#(
  parameter int W  = 32,
  parameter int FW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [W-1:0]     req_freq,
  input  logic             req_sys_mode,
  input  logic [W-1:0]     cfg_ref,
  input  logic [W-1:0]     cfg_vco_min,
  input  logic [W-1:0]     cfg_vco_max,
  input  logic [W-1:0]     cfg_max_clk,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [MW-1:0]    res_m,
  output logic [NBITS-1:0] res_n,
  output logic [PCW-1:0]   res_p_code,
  output logic [W-1:0]     res_freq,
  output logic             res_none,
  output logic             busy
);
  localparam int NW = W + 8;
  localparam int DW = W + 1;
  localparam logic [W-1:0] THR_HI_FX = W'(340) << FW;

  srch_state_t state_q;

  logic [W-1:0]     target_q, ref_q, vmin_q, vmax_q, maxc_q;
  logic             mode_q;
  logic [PCW-1:0]   pidx_q;
  logic [MW-1:0]    m_q;
  logic [NBITS-1:0] n_q;
  logic             found_q;
  logic [MW-1:0]    best_m;
  logic [NBITS-1:0] best_n;
  logic [PCW-1:0]   best_p;
  logic [W-1:0]     best_f;
  logic [NW-1:0]    best_e;

  logic [W-1:0]     limited;
  logic [MW-1:0]    m_first, m_last;
  logic [DHW-1:0]   disc_hi;
  logic             vco_ok, disc_ok;
  logic [NW-1:0]    n_num;
  logic [DW-1:0]    n_den;

  logic             div_start, div_busy, div_done;
  logic [NW-1:0]    div_num, div_quo;
  logic [DW-1:0]    div_den;
  logic [NW-1:0]    cand_err;
  logic             cand_better;

  pll_clamp #(.W(W), .FW(FW)) u_clamp (
    .sys_mode (mode_q),
    .target   (target_q),
    .vco_min  (vmin_q),
    .vco_max  (vmax_q),
    .max_clk  (maxc_q),
    .limited  (limited),
    .m_first  (m_first),
    .m_last   (m_last),
    .disc_hi  (disc_hi)
  );

  pll_cand #(.W(W), .FW(FW), .NW(NW), .DW(DW)) u_cand (
    .limited  (limited),
    .pidx     (pidx_q),
    .m        (m_q),
    .ref_clk  (ref_q),
    .vco_min  (vmin_q),
    .vco_max  (vmax_q),
    .disc_hi  (disc_hi),
    .vco_ok   (vco_ok),
    .disc_ok  (disc_ok),
    .n_num    (n_num),
    .n_den    (n_den)
  );

  pll_div #(.NW(NW), .DW(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  // divider operand selection: N rounding in MCHK, achieved frequency in ASTART
  always_comb begin
    div_start = 1'b0;
    div_num   = n_num;
    div_den   = n_den;
    if (state_q == ST_MCHK) begin
      div_start = (m_q <= m_last) && disc_ok;
    end else if (state_q == ST_ASTART) begin
      div_start = 1'b1;
      div_num   = NW'(ref_q) * NW'(n_q);
      div_den   = DW'(m_q) << pidx_q;
    end
  end

  always_comb begin
    cand_err    = (NW'(limited) >= div_quo) ? (NW'(limited) - div_quo)
                                             : (div_quo - NW'(limited));
    cand_better = !found_q || (cand_err < best_e);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      ref_q    <= '0;
      vmin_q   <= '0;
      vmax_q   <= '0;
      maxc_q   <= '0;
      mode_q   <= 1'b0;
      pidx_q   <= '0;
      m_q      <= '0;
      n_q      <= '0;
      found_q  <= 1'b0;
      best_m   <= '0;
      best_n   <= '0;
      best_p   <= '0;
      best_f   <= '0;
      best_e   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            target_q <= req_freq;
            mode_q   <= req_sys_mode;
            ref_q    <= cfg_ref;
            vmin_q   <= cfg_vco_min;
            vmax_q   <= cfg_vco_max;
            maxc_q   <= cfg_max_clk;
            state_q  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          pidx_q  <= '0;
          found_q <= 1'b0;
          best_m  <= '0;
          best_n  <= '0;
          best_p  <= '0;
          best_f  <= '0;
          best_e  <= '0;
          state_q <= ST_PCHK;
        end
        ST_PCHK: begin
          if (pidx_q == PCW'(P_STEPS)) begin
            state_q <= ST_DONE;
          end else if (!vco_ok) begin
            pidx_q <= pidx_q + PCW'(1);
          end else begin
            m_q     <= m_first;
            state_q <= ST_MCHK;
          end
        end
        ST_MCHK: begin
          if (m_q > m_last) begin
            pidx_q  <= pidx_q + PCW'(1);
            state_q <= ST_PCHK;
          end else if (!disc_ok) begin
            m_q <= m_q + MW'(1);
          end else begin
            state_q <= ST_NWAIT;
          end
        end
        ST_NWAIT: begin
          if (div_done) begin
            if ((div_quo == '0) || (div_quo > NW'(N_MAX))) begin
              m_q     <= m_q + MW'(1);
              state_q <= ST_MCHK;
            end else begin
              n_q     <= div_quo[NBITS-1:0];
              state_q <= ST_ASTART;
            end
          end
        end
        ST_ASTART: begin
          state_q <= ST_AWAIT;
        end
        ST_AWAIT: begin
          if (div_done) begin
            if (cand_better) begin
              found_q <= 1'b1;
              best_m  <= m_q;
              best_n  <= n_q;
              best_p  <= pidx_q;
              best_f  <= W'(div_quo);
              best_e  <= cand_err;
            end
            m_q     <= m_q + MW'(1);
            state_q <= ST_MCHK;
          end
        end
        ST_DONE: begin
          if (res_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign res_valid  = (state_q == ST_DONE);
  assign busy       = !(state_q == ST_IDLE || state_q == ST_DONE);
  assign res_m      = best_m;
  assign res_n      = best_n;
  assign res_p_code = best_p;
  assign res_freq   = best_f;
  assign res_none   = !found_q;

  AST_RES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !busy && !req_ready); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> busy); // R1
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_ready) |=> res_valid && $stable({res_m, res_n, res_p_code, res_freq, res_none})); // R1
  AST_DIV_IDLE_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !div_busy); // R7
  AST_PIX_M_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_none && !mode_q) |-> (res_m >= MW'(7)) && (res_m <= MW'(14))); // R4
  AST_SYS_M_NARROW: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_none && mode_q && (target_q > THR_HI_FX)) |-> (res_m <= MW'(2))); // R5
  AST_N_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_none) |-> res_n != '0); // R6
  AST_P_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> res_p_code <= PCW'(4)); // R8
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_none) |-> (res_m == '0) && (res_n == '0) && (res_p_code == '0) && (res_freq == '0)); // R9
endmodule

// File: tb/pll_coef_search_tb.sv
module pll_coef_search_tb;
  localparam int W = 32;
  localparam int WATCHDOG = 190000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [W-1:0] req_freq = '0;
  logic         req_sys_mode = 1'b0;
  logic [W-1:0] cfg_ref = '0, cfg_vco_min = '0, cfg_vco_max = '0, cfg_max_clk = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [3:0]   res_m;
  logic [7:0]   res_n;
  logic [2:0]   res_p_code;
  logic [W-1:0] res_freq;
  logic         res_none;
  logic         busy;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pll_coef_search #(.W(W), .FW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_freq(req_freq), .req_sys_mode(req_sys_mode), .cfg_ref(cfg_ref),
    .cfg_vco_min(cfg_vco_min), .cfg_vco_max(cfg_vco_max), .cfg_max_clk(cfg_max_clk),
    .res_valid(res_valid), .res_ready(res_ready), .res_m(res_m), .res_n(res_n),
    .res_p_code(res_p_code), .res_freq(res_freq), .res_none(res_none), .busy(busy)
  );

  task automatic chk(input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint unsigned fx(input longint unsigned khz);
    return (khz << 16) / 1000;
  endfunction

  // behavioural reference of the search, written from the requirements
  function automatic void model(input bit sys, input longint unsigned rq, rf, vmn, vmx, mxc,
                                output longint unsigned om, on, op, of, output bit onone);
    longint unsigned c, lo, hi, be, vco, n, a, e;
    int mlo, mhi, dh;
    bit found;
    found = 0; be = 0;
    om = 0; on = 0; op = 0; of = 0;
    lo = vmn >> 4;
    c  = (rq < lo) ? lo : rq;          // R2
    hi = sys ? vmx : mxc;
    if (c > hi) c = hi;
    mlo = sys ? 1 : 7;
    dh  = sys ? 14 : 2;
    if (!sys)                 mhi = 14;
    else if (rq > fx(340000)) mhi = 2;  // R5
    else if (rq > fx(250000)) mhi = 6;
    else                      mhi = 14;
    for (int pi = 0; pi < 5; pi++) begin
      vco = c << pi;
      if (vco < vmn || vco > vmx) continue;
      for (int m = mlo; m <= mhi; m++) begin
        if (rf < (longint'(m) << 16) || rf > (longint'(m * dh) << 16)) continue;
        n = (2 * vco * longint'(m) + rf) / (2 * rf);
        if (n < 1 || n > 255) continue;
        a = (rf * n) / (longint'(m) << pi);
        e = (c > a) ? (c - a) : (a - c);
        if (!found || e < be) begin
          found = 1; be = e;
          om = m; on = n; op = pi; of = a & 64'hFFFF_FFFF;
        end
      end
    end
    onone = !found;
  endfunction

  // per-clock protocol comparison
  bit acc_pend = 0, hold_pend = 0;
  logic [3:0] h_m; logic [7:0] h_n; logic [2:0] h_p; logic [W-1:0] h_f; logic h_none;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (acc_pend) chk("R1", "busy after accept", busy, 1);
      if (res_valid) chk("R1", "busy/ready during result", {busy, req_ready}, 0);
      if (hold_pend) begin
        chk("R1", "held valid", res_valid, 1);
        chk("R1", "held fields", {h_m, h_n, h_p, h_f, h_none},
            {res_m, res_n, res_p_code, res_freq, res_none});
      end
      acc_pend  = req_valid && req_ready;
      hold_pend = res_valid && !res_ready;
      h_m = res_m; h_n = res_n; h_p = res_p_code; h_f = res_freq; h_none = res_none;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_case(input bit sys, input longint unsigned rq_k, rf_k, vmn_k, vmx_k, mxc_k,
                          input string ftag, input bit stall, input bit scramble);
    longint unsigned em, en, ep, ef;
    bit enone;
    model(sys, fx(rq_k), fx(rf_k), fx(vmn_k), fx(vmx_k), fx(mxc_k), em, en, ep, ef, enone);
    @(posedge clk); #1;
    req_sys_mode = sys;
    req_freq     = W'(fx(rq_k));
    cfg_ref      = W'(fx(rf_k));
    cfg_vco_min  = W'(fx(vmn_k));
    cfg_vco_max  = W'(fx(vmx_k));
    cfg_max_clk  = W'(fx(mxc_k));
    req_valid    = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (scramble) begin  // R11: disturb every captured input while busy
      req_sys_mode = ~sys;
      req_freq     = 32'h0123_4567;
      cfg_ref      = 32'h0000_0100;
      cfg_vco_min  = 32'h7FFF_0000;
      cfg_vco_max  = 32'h0001_0000;
      cfg_max_clk  = 32'h0000_0001;
    end
    do @(negedge clk); while (!res_valid);
    chk(sys ? "R5" : "R4", "res_m", res_m, em);
    chk("R6", "res_n", res_n, en);
    chk("R8", "res_p_code", res_p_code, ep);
    chk(ftag, "res_freq", res_freq, ef);
    chk("R9", "res_none", res_none, enone);
    if (stall) repeat (4) @(negedge clk);
    @(posedge clk); #1 res_ready = 1'b1;
    @(posedge clk); #1 res_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "req_ready", req_ready, 1);
    chk("R10", "busy", busy, 0);
    chk("R10", "res_valid", res_valid, 0);
    chk("R10", "fields", {res_m, res_n, res_p_code, res_freq}, 0);

    run_case(0, 65000, 13500, 128000, 350000, 300000, "R7", 0, 0);
    run_case(0,  5000, 13500, 128000, 350000, 300000, "R2", 0, 0);  // raised to vco_min/16
    run_case(0, 400000, 13500, 128000, 350000, 300000, "R2", 1, 0); // lowered to max clock
    run_case(0, 100000, 14000, 128000, 350000, 300000, "R4", 0, 0); // window bounds hit exactly
    run_case(1, 166000, 27000, 128000, 350000, 300000, "R5", 0, 0);
    run_case(1, 300000, 27000, 128000, 350000, 300000, "R5", 0, 0); // M limit 6
    run_case(1, 400000, 27000, 128000, 350000, 300000, "R2", 1, 0); // M limit 2, lowered to vco_max
    run_case(0, 65000, 40000, 128000, 350000, 300000, "R9", 0, 0);  // no candidate
    run_case(0, 25175, 13500, 128000, 350000, 300000, "R3", 1, 0);
    run_case(1, 100000, 13500, 200000, 400000, 300000, "R3", 0, 0); // only P=2,4 in range
    run_case(0, 108000, 13500, 128000, 350000, 300000, "R11", 0, 1);
    run_case(1,  7000, 27000, 128000, 350000, 300000, "R2", 0, 0);
    run_case(1, 260000, 16000, 150000, 700000, 300000, "R7", 0, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule